// File: doc/BRIEF.md
# Ethernet PHY Management Register File

This block is the management register set of one Ethernet PHY, reached through a plain parallel register port. The port has a 5-bit register address, one read strobe and one write strobe, 16-bit write data and 16-bit read data. Inside the block are a control word, a status word, an auto-negotiation advertisement word, a latched interrupt-source byte and an interrupt-mask byte. Fixed identifier, link-partner and expansion words are returned as constants. Serial management framing, real negotiation signalling and any packet data path are outside this block.

A link-up input passes through a synchroniser. Each edge of the synchronised level changes the link bits of the status word and latches interrupt events. Events stay set until software reads the interrupt-source register, and that read also clears them. The level interrupt output is high whenever an unmasked source bit is set. Each writable register has its own write mask. Writing the control word with its reset bit set returns every register to its reset value. Writing the control word with the negotiation-enable bit set marks negotiation as complete at once.

Top module: `phy_mgmt_regs`

## Requirements
- R1: Reads of address 2 return 0x0007, address 3 return 0xC0D1, address 5 return 0x0F71 and address 6 return 0x0001.
- R2: After rst_n is released with link_up low, control (address 0) reads 0x3000, status (address 1) reads 0x7809, advertisement (address 4) reads 0x01E1, interrupt source (address 29) and mask (address 30) read 0, and irq is low.
- R3: A write to address 0 with bit 15 clear stores the write data ANDed with 0x7980 in the control register.
- R4: A write to address 0 with bit 15 clear and bit 12 set sets status bit 5 in the same clock edge.
- R5: A write to address 0 with bit 15 set returns control, advertisement, interrupt source and mask to their reset values. Status returns to 0x7809 with bits 2 and 5 set if the synchronised link is up.
- R6: A write to address 4 stores (data AND 0x2D7F) OR 0x0080.
- R7: A write to address 30 stores bits 7:0 as the interrupt mask. irq is high exactly when (source AND mask) is nonzero.
- R8: The link-up input is sampled by a two-flop synchroniser. An edge is acted on at the third rising clock edge after the input changes. A rising edge sets status bits 2 and 5 and latches source bits 7 (energy on) and 6 (negotiation complete). A falling edge clears status bits 2 and 5 and latches source bit 4 (link down).
- R9: A read of address 29 returns the current sources and clears them at that clock edge. An event arriving in the same cycle as the read is kept. Source bits stay set until such a read.
- R10: Reads of any address other than 0 to 6, 29 and 30 return 0.
- R11: Writes to any address other than 0, 4 and 30 change no register.
- R12: reg_rdata is 0 whenever reg_rd is low. When reg_rd is high it shows the addressed register in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 5 | Register address |
| reg_rd | input | 1 | Read strobe; a read of address 29 clears the sources |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, valid in the cycle reg_rd is high |
| link_up | input | 1 | Asynchronous link state from the line side |
| irq | output | 1 | Level interrupt, source AND mask nonzero |

## Verification
The assertions check on every cycle that source bits only fall on a clearing access and that a clearing read with no new event leaves the sources empty. They also check that every control, advertisement and mask write lands with its mask, and that each synchronised link edge updates status and latches its events one cycle later. Other behaviour can only be shown by the bench's scenarios: the constant and zero-returning address map, the soft reset that pulls the link bits from the current level, ignored writes to read-only and unused addresses, and a link event colliding with a clearing read.

// File: rtl/phy_mgmt_pkg.sv
package phy_mgmt_pkg;
  localparam int unsigned ADDR_W = 5;
  localparam int unsigned DATA_W = 16;
  localparam int unsigned EVT_W  = 8;

  typedef logic [DATA_W-1:0] word_t;
  typedef logic [ADDR_W-1:0] addr_t;

  localparam addr_t A_CTRL = 5'd0;
  localparam addr_t A_STAT = 5'd1;
  localparam addr_t A_IDHI = 5'd2;
  localparam addr_t A_IDLO = 5'd3;
  localparam addr_t A_ADV  = 5'd4;
  localparam addr_t A_LPA  = 5'd5;
  localparam addr_t A_EXP  = 5'd6;
  localparam addr_t A_ISRC = 5'd29;
  localparam addr_t A_IMSK = 5'd30;

  localparam word_t ID_HI_VAL   = 16'h0007;
  localparam word_t ID_LO_VAL   = 16'hC0D1;
  localparam word_t LPA_VAL     = 16'h0F71;
  localparam word_t EXP_VAL     = 16'h0001;
  localparam word_t CTRL_INIT   = 16'h3000;
  localparam word_t STAT_INIT   = 16'h7809;
  localparam word_t ADV_INIT    = 16'h01E1;
  localparam word_t CTRL_KEEP   = 16'h7980;
  localparam word_t ADV_KEEP    = 16'h2D7F;
  localparam word_t ADV_FORCE   = 16'h0080;
  localparam word_t STAT_LINK   = 16'h0024;
  localparam word_t STAT_ANDONE = 16'h0020;

  localparam int unsigned CTRL_SRST_BIT = 15;
  localparam int unsigned CTRL_ANEN_BIT = 12;
  localparam int unsigned EV_DOWN   = 4;
  localparam int unsigned EV_ANEG   = 6;
  localparam int unsigned EV_ENERGY = 7;
endpackage

// File: rtl/link_sync.sv
module link_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic link_in,
  output logic level,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] chain_q, chain_nx;
  logic              prev_q;

  always_comb begin
    chain_nx = {chain_q[STAGES-2:0], link_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      prev_q  <= 1'b0;
    end else begin
      chain_q <= chain_nx;
      prev_q  <= chain_q[STAGES-1];
    end
  end

  assign level = chain_q[STAGES-1];
  assign rise  = level & ~prev_q;
  assign fall  = ~level & prev_q;

  // R8
  edge_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise && !fall);
endmodule

// File: rtl/irq_unit.sv
module irq_unit #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_src,
  input  logic         clr_mask,
  input  logic         mask_we,
  input  logic [W-1:0] mask_wdata,
  input  logic [W-1:0] events,
  output logic [W-1:0] src,
  output logic [W-1:0] mask,
  output logic         irq
);
  logic [W-1:0] src_q, src_nx, mask_q, mask_nx;
  logic         mask_en;

  always_comb begin
    src_nx  = (clr_src ? '0 : src_q) | events;
    mask_en = clr_mask | mask_we;
    mask_nx = clr_mask ? '0 : mask_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q  <= '0;
      mask_q <= '0;
    end else begin
      src_q <= src_nx;
      if (mask_en) mask_q <= mask_nx;
    end
  end

  assign src  = src_q;
  assign mask = mask_q;
  assign irq  = |(src_q & mask_q);

  // R9
  src_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_src && (events == '0) |=> src == '0);
  // R9
  src_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_src |=> (src & $past(src)) == $past(src));
  // R7
  mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mask_we && !clr_mask |=> mask == $past(mask_wdata));
endmodule

// File: rtl/phy_mgmt_regs.sv
module phy_mgmt_regs
  import phy_mgmt_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [4:0]  reg_addr,
  input  logic        reg_rd,
  input  logic        reg_wr,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  input  logic        link_up,
  output logic        irq
);
  word_t ctrl_q, ctrl_nx, stat_q, stat_nx, adv_q, adv_nx;
  logic  ctrl_en, adv_en;
  logic  wr_ctrl, soft_rst, ctrl_ld, src_rd, mask_we;
  logic  lnk_lvl, lnk_rise, lnk_fall;
  logic [EVT_W-1:0] events, src, mask;

  link_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst_n(rst_n), .link_in(link_up),
    .level(lnk_lvl), .rise(lnk_rise), .fall(lnk_fall)
  );

  always_comb begin
    wr_ctrl  = reg_wr && (reg_addr == A_CTRL);
    soft_rst = wr_ctrl && reg_wdata[CTRL_SRST_BIT];
    ctrl_ld  = wr_ctrl && !reg_wdata[CTRL_SRST_BIT];
    adv_en   = soft_rst || (reg_wr && (reg_addr == A_ADV));
    mask_we  = reg_wr && (reg_addr == A_IMSK);
    src_rd   = reg_rd && (reg_addr == A_ISRC);
    ctrl_en  = wr_ctrl;
  end

  always_comb begin
    ctrl_nx = soft_rst ? CTRL_INIT : (reg_wdata & CTRL_KEEP);
    adv_nx  = soft_rst ? ADV_INIT  : ((reg_wdata & ADV_KEEP) | ADV_FORCE);

    stat_nx = stat_q;
    if (soft_rst)
      stat_nx = STAT_INIT | (lnk_lvl ? STAT_LINK : '0);
    else if (ctrl_ld && reg_wdata[CTRL_ANEN_BIT])
      stat_nx = stat_q | STAT_ANDONE;
    if (lnk_rise) stat_nx = stat_nx | STAT_LINK;
    if (lnk_fall) stat_nx = stat_nx & ~STAT_LINK;

    events            = '0;
    events[EV_ENERGY] = lnk_rise;
    events[EV_ANEG]   = lnk_rise;
    events[EV_DOWN]   = lnk_fall;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_INIT;
      stat_q <= STAT_INIT;
      adv_q  <= ADV_INIT;
    end else begin
      if (ctrl_en) ctrl_q <= ctrl_nx;
      if (adv_en)  adv_q  <= adv_nx;
      stat_q <= stat_nx;
    end
  end

  irq_unit #(.W(EVT_W)) i_irq (
    .clk(clk), .rst_n(rst_n),
    .clr_src(src_rd || soft_rst), .clr_mask(soft_rst),
    .mask_we(mask_we), .mask_wdata(reg_wdata[EVT_W-1:0]),
    .events(events), .src(src), .mask(mask), .irq(irq)
  );

  always_comb begin
    reg_rdata = '0;
    if (reg_rd) begin
      unique case (reg_addr)
        A_CTRL:  reg_rdata = ctrl_q;
        A_STAT:  reg_rdata = stat_q;
        A_IDHI:  reg_rdata = ID_HI_VAL;
        A_IDLO:  reg_rdata = ID_LO_VAL;
        A_ADV:   reg_rdata = adv_q;
        A_LPA:   reg_rdata = LPA_VAL;
        A_EXP:   reg_rdata = EXP_VAL;
        A_ISRC:  reg_rdata = {{(DATA_W-EVT_W){1'b0}}, src};
        A_IMSK:  reg_rdata = {{(DATA_W-EVT_W){1'b0}}, mask};
        default: reg_rdata = '0;
      endcase
    end
  end

  // R3
  ctrl_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_ld |=> ctrl_q == ($past(reg_wdata) & CTRL_KEEP));
  // R6
  adv_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && (reg_addr == A_ADV) |=> adv_q == (($past(reg_wdata) & ADV_KEEP) | ADV_FORCE));
  // R4
  aneg_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_ld && reg_wdata[CTRL_ANEN_BIT] && !lnk_fall |=> stat_q[5]);
  // R8
  link_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lnk_rise |=> ((stat_q & STAT_LINK) == STAT_LINK) && src[EV_ENERGY] && src[EV_ANEG]);
  // R8
  link_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lnk_fall |=> ((stat_q & STAT_LINK) == '0) && src[EV_DOWN]);
endmodule

// File: tb/test_phy_mgmt_regs.sv
module test_phy_mgmt_regs;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [4:0]  reg_addr;
  logic        reg_rd, reg_wr;
  logic [15:0] reg_wdata;
  logic [15:0] reg_rdata;
  logic        link_up;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;

  logic [15:0] m_ctrl, m_stat, m_adv;
  logic [7:0]  m_src, m_mask;
  logic        m_link;

  always #2 clk = ~clk;

  phy_mgmt_regs i_phy_mgmt_regs (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_rd(reg_rd),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .link_up(link_up), .irq(irq)
  );

  function automatic logic [15:0] exp_rd(input int a);
    case (a)
      0:  return m_ctrl;
      1:  return m_stat;
      2:  return 16'h0007;
      3:  return 16'hC0D1;
      4:  return m_adv;
      5:  return 16'h0F71;
      6:  return 16'h0001;
      29: return {8'h00, m_src};
      30: return {8'h00, m_mask};
      default: return 16'h0000;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_ctrl = 16'h3000;
    m_stat = 16'h7809 | (m_link ? 16'h0024 : 16'h0000);
    m_adv  = 16'h01E1;
    m_src  = 8'h00;
    m_mask = 8'h00;
  endtask

  task automatic wr(input int a, input logic [15:0] d);
    @(negedge clk);
    reg_addr = a[4:0]; reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk);
    #1 reg_wr = 1'b0;
    if (a == 0) begin
      if (d[15]) model_reset();
      else begin
        m_ctrl = d & 16'h7980;
        if (d[12]) m_stat = m_stat | 16'h0020;
      end
    end else if (a == 4) m_adv = (d & 16'h2D7F) | 16'h0080;
    else if (a == 30) m_mask = d[7:0];
  endtask

  task automatic rd_chk(input int a, input string tag);
    @(negedge clk);
    reg_addr = a[4:0]; reg_rd = 1'b1;
    #1 chk(tag, reg_rdata, exp_rd(a));
    @(posedge clk);
    #1 reg_rd = 1'b0;
    if (a == 29) m_src = 8'h00;
  endtask

  task automatic irq_chk(input string tag);
    @(negedge clk);
    chk(tag, {15'd0, irq}, {15'd0, |(m_src & m_mask)});
  endtask

  task automatic set_link(input logic v);
    @(negedge clk);
    link_up = v;
    repeat (3) @(posedge clk);
    #1;
    m_link = v;
    if (v) begin m_stat = m_stat | 16'h0024; m_src = m_src | 8'hC0; end
    else   begin m_stat = m_stat & ~16'h0024; m_src = m_src | 8'h10; end
  endtask

  initial begin
    #(4 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; reg_addr = '0; reg_rd = 1'b0; reg_wr = 1'b0;
    reg_wdata = '0; link_up = 1'b0; m_link = 1'b0;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R2 R12: idle read data and reset state
    @(negedge clk);
    chk("R12 idle rdata", reg_rdata, 16'h0000);
    irq_chk("R2 irq after reset");
    // R1 R2 R10: full address sweep
    for (int a = 0; a < 32; a++) rd_chk(a, "R1/R2/R10 reset sweep");

    // R3 R4: control writes
    wr(0, 16'h0000);
    rd_chk(1, "R4 status without enable");
    for (int i = 0; i < 32; i++) begin
      wr(0, (16'(i) * 16'h0F3B + 16'h1234) & 16'h7FFF);
      rd_chk(0, "R3 control mask");
      rd_chk(1, "R4 status bit5");
    end

    // R6: advertisement writes
    for (int i = 0; i < 32; i++) begin
      wr(4, 16'(i) * 16'h2B1D ^ 16'hA5C3);
      rd_chk(4, "R6 advertisement");
    end

    // R11: writes to every non-writable address
    for (int a = 1; a < 32; a++)
      if (a != 4 && a != 30) wr(a, 16'hFFFF);
    for (int a = 0; a < 32; a++) rd_chk(a, "R11 ignored writes");

    // R8 R7 R9: link up, masking, read clear
    set_link(1'b1);
    rd_chk(1, "R8 status after link up");
    irq_chk("R7 irq masked off");
    wr(30, 16'h01FF);
    rd_chk(30, "R7 mask low byte");
    irq_chk("R7 irq asserted");
    rd_chk(29, "R9 sources after up");
    irq_chk("R9 irq after clear");
    rd_chk(29, "R9 sources cleared");
    set_link(1'b0);
    rd_chk(1, "R8 status after link down");
    irq_chk("R8 irq on down");
    wr(30, 16'h0040);
    irq_chk("R7 down event masked");
    rd_chk(29, "R8 down source");

    // R9: event in same cycle as clearing read
    @(negedge clk) link_up = 1'b1;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    reg_addr = 5'd29; reg_rd = 1'b1;
    #1 chk("R9 read during event", reg_rdata, 16'h0000);
    @(posedge clk);
    #1 reg_rd = 1'b0;
    m_link = 1'b1; m_stat = m_stat | 16'h0024; m_src = 8'hC0;
    irq_chk("R9 irq kept event");
    rd_chk(29, "R9 event kept");

    // R5: soft reset with link up
    wr(30, 16'h00FF);
    wr(4, 16'h0000);
    wr(0, 16'h0100);
    set_link(1'b0);
    set_link(1'b1);
    wr(0, 16'h8000);
    irq_chk("R5 irq after soft reset");
    for (int a = 0; a < 32; a++) rd_chk(a, "R5 soft reset sweep");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule